// File: doc/BRIEF.md
# Count-Leading-Zeros Execute Unit

This unit decodes and executes one count-leading-zeros instruction per cycle. An instruction word arrives together with a format select. Format 0 is a 32-bit fixed-length layout. Format 1 is a layout of two 16-bit halfwords, with the first halfword in bits 31:16. The unit also receives a condition-passed flag from outside logic. It drives a source register index out to the register file, which is outside the block, and takes back the 32-bit value of that register. It counts the zero bits above the highest set bit of that value.

One cycle after an accepted instruction, the unit presents the following registered outputs:
- a valid strobe;
- a write enable;
- the destination index;
- the result;
- an undefined flag, for words that do not match either layout;
- an unpredictable flag, for words that match but break a register rule.

In the two-halfword layout the source register appears in two fields. When those two fields disagree, a build-time policy decides the outcome. The policy can reject the instruction as undefined, drop it as a no-op, run it as written, take the source from the other field, or write a fixed filler value to the destination.

Top module: `clz_exec_unit`

## Requirements
- R1: On a write, the result equals the number of zero bits above the highest set bit of the source value. A zero source gives 32, and a source with bit 31 set gives 0.
- R2: In format 0, the word matches only when all three of these hold: bits 31:28 are not 4'hF, bits 27:20 equal 8'h16, and bits 7:4 equal 4'h1. Any other word raises the undefined flag, does not write, and leaves the unpredictable flag low.
- R3: In format 1, the word matches only when all three of these hold: bits 31:20 equal 12'hFAB, bits 15:12 equal 4'hF, and bits 7:4 equal 4'h8. Any other word raises the undefined flag and does not write.
- R4: The destination index comes from bits 15:12 in format 0 and from bits 11:8 in format 1. The source index is bits 3:0 in both formats. In format 1, bits 19:16 hold the duplicate of the source index.
- R5: A matched instruction whose destination or source index is 15 raises the unpredictable flag and still writes.
- R6: In format 0, a zero anywhere in bits 19:16 or bits 11:8 raises the unpredictable flag and still writes.
- R7: The write enable is high only for a matched instruction whose condition-passed input was high.
- R8: In format 1, a difference between bits 19:16 and bits 3:0 raises the unpredictable flag, and the outcome depends on the policy parameter:
  - UNDEF raises the undefined flag and does not write.
  - NOP does not write and leaves the undefined flag low.
  - AS_IS reads the source from bits 3:0.
  - USE_RN reads the source from bits 19:16.
  - UNKNOWN writes 32'hDEADBEEF.
- R9: Outputs appear one cycle after the input valid. A cycle with no valid input gives a low valid, write enable, undefined flag and unpredictable flag.
- R10: A synchronous active-high reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_insn | input | 32 | Instruction word |
| in_fmt | input | 1 | 0 = fixed-length layout, 1 = two-halfword layout |
| in_cond_ok | input | 1 | Condition passed |
| src_idx | output | 4 | Register index to read |
| src_val | input | 32 | Value of register src_idx |
| out_valid | output | 1 | Result strobe |
| out_wr_en | output | 1 | Destination write enable |
| out_dst | output | 4 | Destination index |
| out_result | output | 32 | Value to write |
| out_undef | output | 1 | Instruction not recognised or rejected |
| out_unpred | output | 1 | Register rule broken |

## Verification
The bench drives source values at both ends of the count: zero, bit 31 set, and a lone bit 0. A counter that is off by one, or that saturates at 31, fails on these values. Every fixed field of both layouts is corrupted one at a time, including the 4'hF condition value. A decoder that ignores any one field therefore writes when it must not. The bench also uses index 15 and cleared should-be-one bits, which must flag the instruction but still let it write. The mismatched duplicate field is run through all five policies. A unit that always reads bits 3:0 gives a different count from a unit that honours the Rn policy, because the register model holds a distinct power of two in each register.

// File: rtl/clz_exec_pkg.sv
package clz_exec_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    MM_UNDEF,
    MM_NOP,
    MM_AS_IS,
    MM_USE_RN,
    MM_UNKNOWN
  } mm_policy_e;

  typedef struct packed {
    logic             match;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rm;
    logic [IDX_W-1:0] rn;
    logic             sbo_bad;
    logic             pc_used;
    logic             mismatch;
  } dec_t;
endpackage

// File: rtl/clz_decode.sv
module clz_decode
  import clz_exec_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        fmt,
  output dec_t        dec
);
  localparam logic [IDX_W-1:0] PC_IDX = '1;

  always_comb begin
    dec = '0;
    if (!fmt) begin
      dec.match   = (insn[31:28] != 4'hF) && (insn[27:20] == 8'h16) && (insn[7:4] == 4'h1);
      dec.rd      = insn[15:12];
      dec.rm      = insn[3:0];
      dec.rn      = insn[3:0];
      dec.sbo_bad = (insn[19:16] != 4'hF) || (insn[11:8] != 4'hF);
    end else begin
      dec.match   = (insn[31:20] == 12'hFAB) && (insn[15:12] == 4'hF) && (insn[7:4] == 4'h8);
      dec.rd      = insn[11:8];
      dec.rm      = insn[3:0];
      dec.rn      = insn[19:16];
    end
    dec.pc_used  = (dec.rd == PC_IDX) || (dec.rm == PC_IDX);
    dec.mismatch = (dec.rm != dec.rn);
  end
endmodule

// File: rtl/clz_count.sv
module clz_count #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/clz_exec_unit.sv
module clz_exec_unit
  import clz_exec_pkg::*;
#(
  parameter int          DW      = 32,
  parameter mm_policy_e  POLICY  = MM_USE_RN,
  parameter logic [31:0] UNK_VAL = 32'hDEADBEEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   in_insn,
  input  logic          in_fmt,
  input  logic          in_cond_ok,
  output logic [3:0]    src_idx,
  input  logic [DW-1:0] src_val,
  output logic          out_valid,
  output logic          out_wr_en,
  output logic [3:0]    out_dst,
  output logic [DW-1:0] out_result,
  output logic          out_undef,
  output logic          out_unpred
);
  localparam int  CW        = $clog2(DW + 1);
  localparam bit  P_REJECT  = (POLICY == MM_UNDEF);
  localparam bit  P_DROP    = (POLICY == MM_UNDEF) || (POLICY == MM_NOP);
  localparam bit  P_RN      = (POLICY == MM_USE_RN);
  localparam bit  P_FILL    = (POLICY == MM_UNKNOWN);

  dec_t          dec;
  logic [CW-1:0] cnt;
  logic          mm, undef_n, unpred_n, we_n;
  logic [DW-1:0] res_n;

  clz_decode u_dec (
    .insn (in_insn),
    .fmt  (in_fmt),
    .dec  (dec)
  );

  assign mm      = in_fmt && dec.mismatch;
  assign src_idx = (mm && P_RN) ? dec.rn : dec.rm;

  clz_count #(.W(DW), .CW(CW)) u_cnt (
    .val (src_val),
    .cnt (cnt)
  );

  always_comb begin
    undef_n  = !dec.match || (mm && P_REJECT);
    unpred_n = dec.match && (dec.pc_used || dec.sbo_bad || mm);
    we_n     = dec.match && in_cond_ok && !(mm && P_DROP);
    res_n    = (mm && P_FILL) ? DW'(UNK_VAL) : DW'(cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_wr_en  <= 1'b0;
      out_dst    <= '0;
      out_result <= '0;
      out_undef  <= 1'b0;
      out_unpred <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_wr_en  <= in_valid && we_n;
      out_dst    <= in_valid ? dec.rd : '0;
      out_result <= (in_valid && we_n) ? res_n : '0;
      out_undef  <= in_valid && undef_n;
      out_unpred <= in_valid && unpred_n;
    end
  end
endmodule

// File: rtl/clz_exec_unit_chk.sv
module clz_exec_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [31:0]   in_insn,
  input logic          in_fmt,
  input logic          in_cond_ok,
  input logic          out_valid,
  input logic          out_wr_en,
  input logic [DW-1:0] out_result,
  input logic          out_undef,
  input logic          out_unpred
);
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_wr_en && !out_undef && !out_unpred));

  p_write_cond_r7: assert property (@(posedge clk) disable iff (rst)
    out_wr_en |-> $past(in_valid && in_cond_ok));

  p_undef_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> !out_wr_en);

  p_cond_field_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && !in_fmt && (in_insn[31:28] == 4'hF))) |-> out_undef);

  p_result_range_r1: assert property (@(posedge clk) disable iff (rst)
    (out_wr_en && (out_result != DW'(32'hDEADBEEF))) |-> (out_result <= DW'(DW)));
endmodule

bind clz_exec_unit clz_exec_unit_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_insn    (in_insn),
  .in_fmt     (in_fmt),
  .in_cond_ok (in_cond_ok),
  .out_valid  (out_valid),
  .out_wr_en  (out_wr_en),
  .out_result (out_result),
  .out_undef  (out_undef),
  .out_unpred (out_unpred)
);

// File: tb/clz_exec_unit_tb_top.sv
module clz_exec_unit_tb_top;
  import clz_exec_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NV         = 19;

  typedef struct packed {
    logic        fmt;
    logic        cok;
    logic [31:0] insn;
    logic [31:0] val;
    logic        we;
    logic [31:0] res;
    logic        ud;
    logic        up;
    logic [3:0]  dst;
  } vec_t;

  function automatic vec_t mk(logic f, logic c, logic [31:0] i, logic [31:0] v,
                              logic w, logic [31:0] r, logic u, logic p, logic [3:0] d);
    mk = '{fmt: f, cok: c, insn: i, val: v, we: w, res: r, ud: u, up: p, dst: d};
  endfunction

  localparam vec_t VECS [NV] = '{
    mk(0, 1, 32'hE16F2F13, 32'h0001_0000, 1, 15, 0, 0, 2),
    mk(0, 1, 32'hE16F2F13, 32'h0000_0000, 1, 32, 0, 0, 2),
    mk(0, 1, 32'hE16F2F13, 32'h8000_0000, 1,  0, 0, 0, 2),
    mk(0, 1, 32'hE16F2F13, 32'h0000_0001, 1, 31, 0, 0, 2),
    mk(0, 1, 32'hF16F2F13, 32'h0000_0001, 0,  0, 1, 0, 2),
    mk(0, 1, 32'hE17F2F13, 32'h0000_0001, 0,  0, 1, 0, 2),
    mk(0, 1, 32'hE16F2F23, 32'h0000_0001, 0,  0, 1, 0, 2),
    mk(0, 1, 32'hE1602013, 32'h0000_0F00, 1, 20, 0, 1, 2),
    mk(0, 1, 32'hE16FFF13, 32'hFFFF_FFFF, 1,  0, 0, 1, 15),
    mk(0, 1, 32'hE16F2F1F, 32'h0000_8000, 1, 16, 0, 1, 2),
    mk(0, 0, 32'hE16F2F13, 32'h0000_0001, 0,  0, 0, 0, 2),
    mk(1, 1, 32'hFAB7F487, 32'h0000_0400, 1, 21, 0, 0, 4),
    mk(1, 0, 32'hFAB7F487, 32'h0000_0400, 0,  0, 0, 0, 4),
    mk(1, 1, 32'hFAA7F487, 32'h0000_0400, 0,  0, 1, 0, 4),
    mk(1, 1, 32'hFAB7E487, 32'h0000_0400, 0,  0, 1, 0, 4),
    mk(1, 1, 32'hFAB7F497, 32'h0000_0400, 0,  0, 1, 0, 4),
    mk(1, 1, 32'hFAB5F487, 32'h0000_0400, 1, 26, 0, 1, 4),
    mk(1, 1, 32'hFAB7FF87, 32'h0000_0003, 1, 30, 0, 1, 15),
    mk(0, 1, 32'hE16F2F13, 32'h0000_00FF, 1, 24, 0, 0, 2)
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic        in_fmt = 1'b0;
  logic        in_cond_ok = 1'b0;
  logic [31:0] rf [16];

  logic [3:0]  si [5];
  logic [31:0] sv [5];
  logic        ov [5];
  logic        owe [5];
  logic [3:0]  od [5];
  logic [31:0] ores [5];
  logic        oud [5];
  logic        oup [5];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  for (genvar k = 0; k < 5; k++) begin : g_src
    assign sv[k] = rf[si[k]];
  end

  clz_exec_unit #(.POLICY(MM_USE_RN)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_fmt(in_fmt),
    .in_cond_ok(in_cond_ok), .src_idx(si[0]), .src_val(sv[0]), .out_valid(ov[0]),
    .out_wr_en(owe[0]), .out_dst(od[0]), .out_result(ores[0]), .out_undef(oud[0]),
    .out_unpred(oup[0]));

  clz_exec_unit #(.POLICY(MM_UNDEF)) dut_undef (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_fmt(in_fmt),
    .in_cond_ok(in_cond_ok), .src_idx(si[1]), .src_val(sv[1]), .out_valid(ov[1]),
    .out_wr_en(owe[1]), .out_dst(od[1]), .out_result(ores[1]), .out_undef(oud[1]),
    .out_unpred(oup[1]));

  clz_exec_unit #(.POLICY(MM_NOP)) dut_nop (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_fmt(in_fmt),
    .in_cond_ok(in_cond_ok), .src_idx(si[2]), .src_val(sv[2]), .out_valid(ov[2]),
    .out_wr_en(owe[2]), .out_dst(od[2]), .out_result(ores[2]), .out_undef(oud[2]),
    .out_unpred(oup[2]));

  clz_exec_unit #(.POLICY(MM_AS_IS)) dut_asis (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_fmt(in_fmt),
    .in_cond_ok(in_cond_ok), .src_idx(si[3]), .src_val(sv[3]), .out_valid(ov[3]),
    .out_wr_en(owe[3]), .out_dst(od[3]), .out_result(ores[3]), .out_undef(oud[3]),
    .out_unpred(oup[3]));

  clz_exec_unit #(.POLICY(MM_UNKNOWN)) dut_unk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_fmt(in_fmt),
    .in_cond_ok(in_cond_ok), .src_idx(si[4]), .src_val(sv[4]), .out_valid(ov[4]),
    .out_wr_en(owe[4]), .out_dst(od[4]), .out_result(ores[4]), .out_undef(oud[4]),
    .out_unpred(oup[4]));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load_rf(logic [3:0] rm, logic [31:0] v);
    for (int k = 0; k < 16; k++) rf[k] = 32'h1 << k;
    rf[rm] = v;
  endtask

  task automatic issue(logic f, logic c, logic [31:0] i);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = f; in_cond_ok = c; in_insn = i;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    load_rf(4'd0, 32'h0);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid after reset", 32'(ov[0]), 0);
    chk("R10 wr_en after reset", 32'(owe[0]), 0);
    chk("R10 result after reset", ores[0], 0);
    rst = 1'b0;

    // R9 idle cycle
    @(negedge clk);
    chk("R9 idle valid", 32'(ov[0]), 0);
    chk("R9 idle undef", 32'(oud[0]), 0);

    for (int n = 0; n < NV; n++) begin
      load_rf(VECS[n].insn[3:0], VECS[n].val);
      issue(VECS[n].fmt, VECS[n].cok, VECS[n].insn);
      chk($sformatf("R9 vec%0d valid", n), 32'(ov[0]), 1);
      chk($sformatf("R2/R3 vec%0d undef", n), 32'(oud[0]), 32'(VECS[n].ud));
      chk($sformatf("R5/R6/R8 vec%0d unpred", n), 32'(oup[0]), 32'(VECS[n].up));
      chk($sformatf("R7 vec%0d wr_en", n), 32'(owe[0]), 32'(VECS[n].we));
      if (VECS[n].we) begin
        chk($sformatf("R1 vec%0d result", n), ores[0], VECS[n].res);
        chk($sformatf("R4 vec%0d dst", n), 32'(od[0]), 32'(VECS[n].dst));
      end
    end

    // R8 policies on Rn=5, Rm=7 mismatch; rf[5]=0x20, rf[7]=0x400
    load_rf(4'd7, 32'h0000_0400);
    issue(1'b1, 1'b1, 32'hFAB5F487);
    chk("R8 undef policy flag", 32'(oud[1]), 1);
    chk("R8 undef policy wr", 32'(owe[1]), 0);
    chk("R8 nop policy flag", 32'(oud[2]), 0);
    chk("R8 nop policy wr", 32'(owe[2]), 0);
    chk("R8 nop policy unpred", 32'(oup[2]), 1);
    chk("R8 as-is policy wr", 32'(owe[3]), 1);
    chk("R8 as-is policy result", ores[3], 21);
    chk("R8 use-rn policy result", ores[0], 26);
    chk("R8 unknown policy wr", 32'(owe[4]), 1);
    chk("R8 unknown policy result", ores[4], 32'hDEADBEEF);

    // R8 matching fields: all policies behave normally
    load_rf(4'd7, 32'h0000_0400);
    issue(1'b1, 1'b1, 32'hFAB7F487);
    chk("R8 undef policy clean", ores[1], 21);
    chk("R8 unknown policy clean", ores[4], 21);

    // R10 reset wins over an instruction
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_fmt = 1'b0; in_cond_ok = 1'b1; in_insn = 32'hE16F2F13;
    @(negedge clk);
    chk("R10 reset valid", 32'(ov[0]), 0);
    chk("R10 reset wr_en", 32'(owe[0]), 0);
    chk("R10 reset dst", 32'(od[0]), 0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    chk("R9 post-reset idle", 32'(ov[0]), 0);

    finish_run();
  end
endmodule